// File: doc/BRIEF.md
# Attribute Pixel Output Unit

This block turns video data bytes into a stream of 6-bit colour values. It sits behind a processor that handles one video byte per CPU cycle, and a CPU cycle lasts four pixel clocks. Each byte can update a foreground colour register, a background colour register and an 8-bit wide pixel-data register. A 4-bit pixel register is loaded from every byte. In the CPU cycle that follows the load, the unit shows four pixels, one per pixel clock. A pixel bit of 1 shows the background colour and a pixel bit of 0 shows the foreground colour.

Load strobes state which registers take the byte. A shift control passes the byte through a left shift that brings a 1 into bit 0 before it is stored. The pixel source select, the force-background control and the blank control are captured with the byte and hold for the whole next CPU cycle. With these controls, one datapath can produce 320-pixel colour-attribute lines, 640-pixel two-colour lines, and packed text formats that pad each character with background pixels.

The unit runs entirely on the pixel clock. It drives `load_slot` high during the last pixel clock of each CPU cycle. The byte and the controls are sampled at the rising edge that ends that clock.

Top module: `attr_pix_unit`

## Requirements
- R1: In reset and on the first clocks after it, `pix_color` is 0 and `load_slot` is low. Both colour registers, the pixel register and the data register clear to 0, and the unit starts blanked.
- R2: `load_slot` is high for one clock in every four. All loads and controls are sampled at the edge that ends that clock. The four pixels of a byte appear on `pix_color` in the next four clocks after it, the first one a single clock after the sampling edge.
- R3: With `ld_fg` set, byte value bits 6..1 are written to the foreground register. With `ld_bg` set, the same bits are written to the background register. A colour register whose strobe is clear keeps its value.
- R4: A displayed pixel bit of 1 shows the background colour and a pixel bit of 0 shows the foreground colour.
- R5: On a plain load (`ld_shl` = 0), the pixel register becomes {d[0], d[0], d[7], d[7]}. Its bits are shown from bit 3 down to bit 0.
- R6: On a shift load (`ld_shl` = 1), the stored value is {d[6:0], 1}, so a colour strobe writes d[5:0]. The pixel register becomes {1, 1, d[7], d[6]}, so the first two pixels always show background.
- R7: With `ld_dph` set, the stored value (plain or shifted) goes into the data register. When the data register is the source, its bits 5..2 are shown, bit 5 first. The register holds its value while `ld_dph` is clear.
- R8: `src_dph` is captured with the byte and picks the pixel source for the whole next CPU cycle: 1 picks data-register bits 5..2, 0 picks the pixel register.
- R9: When `force_bg` is captured high, all four pixels of the next CPU cycle show the background colour, whatever the pixel bits are.
- R10: When `blank` is captured high, all four pixels of the next CPU cycle are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vid_byte | input | 8 | Video data byte for this CPU cycle |
| ld_fg | input | 1 | Write the colour field to the foreground register |
| ld_bg | input | 1 | Write the colour field to the background register |
| ld_dph | input | 1 | Write the byte value to the pixel-data register |
| ld_shl | input | 1 | Shift the byte left with a 1 into bit 0 before storing |
| src_dph | input | 1 | Next cycle's pixels come from data-register bits 5..2 |
| force_bg | input | 1 | Next cycle shows the background colour only |
| blank | input | 1 | Next cycle's output is forced to 0 |
| load_slot | output | 1 | High in the clock whose closing edge samples the inputs |
| pix_color | output | 6 | Colour of the current pixel |

## Verification
Three cases are the hardest to reach from the ports. The first is a cycle that shows a data register loaded several cycles earlier, after plain no-op bytes have passed through the pixel register in between. The second is a shift load whose new colour lands in the same register that its own padded pixels select. The third is a source select that changes while the colour registers change in the same cycle. Directed sequences set up each of these on purpose. Random cycles then mix the load strobes, the shift control and the source select. A bench model follows every register across cycles, so a stale value or a display that is off by one clock changes a checked pixel.

// File: rtl/attr_pix_pkg.sv
// Package: shared widths and field positions of the attribute pixel unit.
// Assumes one 8-bit byte per CPU cycle carrying a 6-bit colour at bits 6..1.
package attr_pix_pkg;
    localparam int BYTE_W   = 8;
    localparam int COLOR_W  = 6;
    localparam int COLOR_LO = 1;
    localparam int NIB_W    = 4;
    localparam int DPH_LO   = 2;

    // Per-cycle display controls captured together with the byte.
    typedef struct packed {
        logic src_dph;
        logic force_bg;
        logic blank;
    } cyc_ctl_t;
endpackage

// File: rtl/attr_pix_phase.sv
// Module: pixel phase counter. Counts pixel clocks inside one CPU cycle and
// flags the last one, whose closing edge samples the byte and controls.
// Assumes PHASES is at least 2.
module attr_pix_phase #(
    parameter int PHASES = 4,
    localparam int PH_W  = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            slot
);
    // Wraps the phase count at the end of each CPU cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (phase == PH_W'(PHASES - 1))
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    assign slot = (phase == PH_W'(PHASES - 1));
endmodule

// File: rtl/attr_pix_regs.sv
// Module: video register set. Holds foreground, background, pixel and
// pixel-data registers plus the captured cycle controls; all update only
// when take is high. Assumes the byte layout given in attr_pix_pkg.
module attr_pix_regs
    import attr_pix_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic [BYTE_W-1:0]  byte_in,
    input  logic               ld_fg,
    input  logic               ld_bg,
    input  logic               ld_dph,
    input  logic               ld_shl,
    input  cyc_ctl_t           ctl_in,
    output logic [COLOR_W-1:0] fg_q,
    output logic [COLOR_W-1:0] bg_q,
    output logic [NIB_W-1:0]   pix_q,
    output logic [BYTE_W-1:0]  dph_q,
    output cyc_ctl_t           ctl_q
);
    logic [BYTE_W-1:0]  val;
    logic [NIB_W-1:0]   pix_nx;
    logic [COLOR_W-1:0] col;

    // Forms the stored value and the pixel nibble for plain or shifted loads.
    always_comb begin
        if (ld_shl) begin
            val    = {byte_in[BYTE_W-2:0], 1'b1};
            pix_nx = {2'b11, byte_in[BYTE_W-1], byte_in[BYTE_W-2]};
        end else begin
            val    = byte_in;
            pix_nx = {byte_in[0], byte_in[0], byte_in[BYTE_W-1], byte_in[BYTE_W-1]};
        end
        col = val[COLOR_LO +: COLOR_W];
    end

    // Loads the colour registers under their strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fg_q <= '0;
            bg_q <= '0;
        end else if (take) begin
            if (ld_fg) fg_q <= col;
            if (ld_bg) bg_q <= col;
        end
    end

    // Loads the pixel register every cycle and the data register on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q <= '0;
            dph_q <= '0;
        end else if (take) begin
            pix_q <= pix_nx;
            if (ld_dph) dph_q <= val;
        end
    end

    // Captures the display controls for the following CPU cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '{src_dph: 1'b0, force_bg: 1'b0, blank: 1'b1};
        else if (take)
            ctl_q <= ctl_in;
    end
endmodule

// File: rtl/attr_pix_mux.sv
// Module: pixel selector and output register. Picks the nibble source,
// orders its bits most significant first by phase, maps the bit to a
// colour and registers the result. Assumes PHASES equals NIB_W.
module attr_pix_mux
    import attr_pix_pkg::*;
#(
    parameter int PHASES = NIB_W,
    localparam int PH_W  = $clog2(PHASES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PH_W-1:0]    phase,
    input  logic [COLOR_W-1:0] fg_q,
    input  logic [COLOR_W-1:0] bg_q,
    input  logic [NIB_W-1:0]   pix_q,
    input  logic [BYTE_W-1:0]  dph_q,
    input  cyc_ctl_t           ctl_q,
    output logic [COLOR_W-1:0] color
);
    logic [NIB_W-1:0] nib;
    logic [NIB_W-1:0] order;
    logic             bit_sel;

    assign nib = ctl_q.src_dph ? dph_q[DPH_LO +: NIB_W] : pix_q;

    for (genvar k = 0; k < NIB_W; k++) begin : g_order
        assign order[k] = nib[NIB_W-1-k];
    end

    assign bit_sel = order[phase];

    // Registers the colour of the pixel for the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            color <= '0;
        else if (ctl_q.blank)
            color <= '0;
        else if (ctl_q.force_bg || bit_sel)
            color <= bg_q;
        else
            color <= fg_q;
    end
endmodule

// File: rtl/attr_pix_unit.sv
// Module: attribute pixel output unit, top level. Samples one video byte
// and its controls per CPU cycle and shows four pixels in the next cycle.
// Assumes the pixel clock runs at four times the CPU cycle rate.
module attr_pix_unit
    import attr_pix_pkg::*;
#(
    parameter int PHASES = NIB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BYTE_W-1:0]  vid_byte,
    input  logic               ld_fg,
    input  logic               ld_bg,
    input  logic               ld_dph,
    input  logic               ld_shl,
    input  logic               src_dph,
    input  logic               force_bg,
    input  logic               blank,
    output logic               load_slot,
    output logic [COLOR_W-1:0] pix_color
);
    localparam int PH_W = $clog2(PHASES);

    logic [PH_W-1:0]    phase;
    logic [COLOR_W-1:0] fg_q;
    logic [COLOR_W-1:0] bg_q;
    logic [NIB_W-1:0]   pix_q;
    logic [BYTE_W-1:0]  dph_q;
    cyc_ctl_t           ctl_in;
    cyc_ctl_t           ctl_q;
    logic               force_q;
    logic               blank_q;

    assign ctl_in  = '{src_dph: src_dph, force_bg: force_bg, blank: blank};
    assign force_q = ctl_q.force_bg;
    assign blank_q = ctl_q.blank;

    attr_pix_phase #(.PHASES(PHASES)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .slot  (load_slot)
    );

    attr_pix_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (load_slot),
        .byte_in (vid_byte),
        .ld_fg   (ld_fg),
        .ld_bg   (ld_bg),
        .ld_dph  (ld_dph),
        .ld_shl  (ld_shl),
        .ctl_in  (ctl_in),
        .fg_q    (fg_q),
        .bg_q    (bg_q),
        .pix_q   (pix_q),
        .dph_q   (dph_q),
        .ctl_q   (ctl_q)
    );

    attr_pix_mux #(.PHASES(PHASES)) u_mux (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .fg_q  (fg_q),
        .bg_q  (bg_q),
        .pix_q (pix_q),
        .dph_q (dph_q),
        .ctl_q (ctl_q),
        .color (pix_color)
    );
endmodule

// File: rtl/attr_pix_unit_chk.sv
// Module: assertion checker for attr_pix_unit, attached by bind.
// Assumes synchronous active-low reset held for at least one clock.
module attr_pix_unit_chk
    import attr_pix_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               load_slot,
    input logic               ld_shl,
    input logic [COLOR_W-1:0] pix_color,
    input logic [COLOR_W-1:0] fg_q,
    input logic [COLOR_W-1:0] bg_q,
    input logic [NIB_W-1:0]   pix_q,
    input logic               force_q,
    input logic               blank_q
);
    p_slot_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_slot |=> !load_slot);

    p_colour_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_slot |=> ($stable(fg_q) && $stable(bg_q)));

    p_colour_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!blank_q) |-> (pix_color == $past(fg_q) || pix_color == $past(bg_q)));

    p_shift_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_slot && ld_shl) |=> (pix_q[NIB_W-1 -: 2] == 2'b11));

    p_force_bg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(force_q && !blank_q) |-> (pix_color == $past(bg_q)));

    p_blank_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(blank_q) |-> (pix_color == '0));
endmodule

bind attr_pix_unit attr_pix_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_slot (load_slot),
    .ld_shl    (ld_shl),
    .pix_color (pix_color),
    .fg_q      (fg_q),
    .bg_q      (bg_q),
    .pix_q     (pix_q),
    .force_q   (force_q),
    .blank_q   (blank_q)
);

// File: tb/attr_pix_unit_test.sv
module attr_pix_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] vid_byte = '0;
    logic       ld_fg = 0, ld_bg = 0, ld_dph = 0, ld_shl = 0;
    logic       src_dph = 0, force_bg = 0, blank = 1;
    logic       load_slot;
    logic [5:0] pix_color;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 0;

    // bench model state
    logic [5:0] m_fg = 0, m_bg = 0;
    logic [3:0] m_pix = 0;
    logic [7:0] m_dph = 0;
    logic       m_sel = 0, m_force = 0, m_blank = 1;
    logic [5:0] cur [4];
    logic [5:0] nxt [4];
    string      cur_tag = "";
    bit         have_cur = 0;

    attr_pix_unit uut (
        .clk(clk), .rst_n(rst_n), .vid_byte(vid_byte),
        .ld_fg(ld_fg), .ld_bg(ld_bg), .ld_dph(ld_dph), .ld_shl(ld_shl),
        .src_dph(src_dph), .force_bg(force_bg), .blank(blank),
        .load_slot(load_slot), .pix_color(pix_color)
    );

    always #2 clk = ~clk;

    task automatic check(input logic [5:0] act, input logic [5:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pix_color=%0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] pixel_of(input int k);
        logic [3:0] nib;
        logic       b;
        nib = m_sel ? m_dph[5:2] : m_pix;
        b   = nib[3-k];
        if (m_blank) return 6'h00;
        if (m_force || b) return m_bg;
        return m_fg;
    endfunction

    // One CPU cycle: drive at the sampling slot, check the previous cycle's pixels.
    task automatic run_cycle(input logic [7:0] d, input logic f, input logic g,
                             input logic h, input logic s, input logic sel,
                             input logic frc, input logic blk, input string tag);
        logic [7:0] v;
        @(negedge clk);
        while (load_slot !== 1'b1) @(negedge clk);
        if (have_cur) check(pix_color, cur[2], cur_tag);
        vid_byte = d; ld_fg = f; ld_bg = g; ld_dph = h; ld_shl = s;
        src_dph = sel; force_bg = frc; blank = blk;
        v = s ? {d[6:0], 1'b1} : d;
        if (f) m_fg = v[6:1];
        if (g) m_bg = v[6:1];
        if (h) m_dph = v;
        m_pix = s ? {2'b11, d[7], d[6]} : {d[0], d[0], d[7], d[7]};
        m_sel = sel; m_force = frc; m_blank = blk;
        for (int k = 0; k < 4; k++) nxt[k] = pixel_of(k);
        @(negedge clk);
        if (have_cur) check(pix_color, cur[3], cur_tag);
        for (int k = 0; k < 4; k++) cur[k] = nxt[k];
        cur_tag = tag; have_cur = 1;
        @(negedge clk); check(pix_color, cur[0], tag);
        @(negedge clk); check(pix_color, cur[1], tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int gap;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(pix_color, 6'h00, "R1 reset colour");
        n_checks++;
        if (load_slot !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: load_slot=%0b expected 0", load_slot);
        end
        @(negedge clk); rst_n = 1;
        repeat (2) @(negedge clk);
        check(pix_color, 6'h00, "R1 blanked after reset");
        // R2: slot period
        while (load_slot !== 1'b1) @(negedge clk);
        gap = 0;
        do begin @(negedge clk); gap++; end while (load_slot !== 1'b1);
        n_checks++;
        if (gap != 4) begin
            n_fail++;
            $display("FAIL R2: slot period=%0d expected 4", gap);
        end
        // directed cases
        run_cycle(8'h54, 0, 1, 0, 0, 0, 0, 0, "R3 bg load");
        run_cycle(8'hAB, 1, 0, 0, 0, 0, 0, 0, "R4 all ones show bg");
        run_cycle(8'h80, 0, 0, 0, 0, 0, 0, 0, "R5 plain nibble order");
        run_cycle(8'h01, 0, 0, 0, 0, 0, 0, 0, "R5 plain low bit");
        run_cycle(8'hB3, 1, 0, 0, 1, 0, 0, 0, "R6 shift pad");
        run_cycle(8'h3F, 0, 1, 0, 1, 0, 0, 0, "R6 shift into bg");
        run_cycle(8'h28, 0, 0, 1, 0, 1, 0, 0, "R7 data register");
        run_cycle(8'hFF, 0, 0, 0, 0, 1, 0, 0, "R7 data register holds");
        run_cycle(8'h55, 0, 0, 1, 1, 1, 0, 0, "R7 shifted data");
        run_cycle(8'h01, 1, 0, 0, 0, 0, 0, 0, "R8 select back to pixel reg");
        run_cycle(8'h00, 0, 0, 0, 0, 1, 0, 0, "R8 select data reg again");
        run_cycle(8'h00, 0, 0, 0, 0, 0, 1, 0, "R9 force background");
        run_cycle(8'hC6, 1, 1, 0, 0, 0, 0, 1, "R10 blank");
        run_cycle(8'h81, 0, 0, 0, 0, 0, 0, 0, "R3 both colours held");
        // random cycles
        for (int i = 0; i < 400; i++) begin
            logic [7:0] d;
            logic [3:0] ld;
            logic       sel, frc, blk;
            string      tg;
            d   = 8'($urandom);
            ld  = 4'($urandom);
            sel = 1'($urandom);
            frc = ($urandom % 8) == 0;
            blk = ($urandom % 8) == 0;
            tg  = blk ? "R10 random" : frc ? "R9 random" : sel ? "R7 random" :
                  ld[3] ? "R6 random" : "R5 random";
            run_cycle(d, ld[0], ld[1], ld[2], ld[3], sel, frc, blk, tg);
        end
        run_cycle(8'h00, 0, 0, 0, 0, 0, 0, 1, "R10 flush");
        run_cycle(8'h00, 0, 0, 0, 0, 0, 0, 1, "R10 flush");
        finish_run();
    end
endmodule